// File: doc/BRIEF.md
# Write-Triggered Accumulator ALU

This unit holds a 64-bit accumulator together with a carry flag and a zero flag. It sits on a plain word-wide address/strobe port of a machine that has no opcodes, only moves. Storing a word to one of the operation addresses is what starts the operation. The stored word is combined with the accumulator, and the result and both flags are committed on the next clock edge.

Loading the same addresses gives status words instead of the operands that went in. These are the carry and zero flags, the population count of the accumulator, and four bit-scan counts: runs of ones or zeros measured from either end of the word. The compare address reads as all ones. Both flags also leave the block as ports, so neighbouring logic can use them directly.

Read data is combinational from the current state. A read and a write in the same cycle therefore see the state from before that write.

Top module: `acc_alu_unit`

## Requirements
- R1: After a synchronous active-low reset the accumulator is 0, carry is 0 and zero is 1.
- R2: A write to offset 0 loads the accumulator and sets zero from the new value, leaving carry unchanged. A read of offset 0 returns the accumulator.
- R3: Writes to offsets 1, 2 and 3 replace the accumulator with its bitwise AND, OR and XOR with the data respectively. Each clears carry and sets zero from the result.
- R4: A write to offset 4 adds the data to the accumulator. A write to offset 5 adds the data plus the carry. Carry becomes the carry-out of bit 63 and zero is set from the sum.
- R5: A write to offset 6 sets the accumulator to accumulator minus data. A write to offset 7 also subtracts the carry. Carry becomes 1 exactly when the unsigned difference goes below zero, and zero is set from the result.
- R6: A write to offset 8 sets carry and zero as offset 6 would, with the accumulator unchanged. A read of offset 8 returns all ones.
- R7: A read of offset 1 returns carry in bit 0, and a read of offset 2 returns zero in bit 0. All other bits of both reads are 0.
- R8: A read of offset 3 returns the number of set accumulator bits, from 0 to 64.
- R9: A read of offset 4 returns the count of consecutive ones starting at bit 0. A read of offset 5 returns the count of zeros below the lowest set bit. Both are 64 when the whole word is of that value.
- R10: A read of offset 6 returns the count of consecutive ones starting at bit 63. A read of offset 7 returns the count of zeros above the highest set bit. Both are 64 when the whole word is of that value.
- R11: Reads return 0 when the read strobe is low or the offset is 9 or above. A write with the strobe low or to offset 9 or above leaves the accumulator and flags unchanged.
- R12: A read issued in the same cycle as a write returns the value from before that write. The update is visible from the next cycle.
- R13: The carry_o and zero_o ports always show the current flag state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W (4) | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe, triggers the operation |
| wr_data | input | W (64) | Operand for a write |
| rd_data | output | W (64) | Read result, combinational |
| carry_o | output | 1 | Carry / borrow flag |
| zero_o | output | 1 | Zero flag |

## Verification
Every piece of state is visible without a lag. The accumulator reads back through offset 0, and the flags appear on their own ports and at offsets 1 and 2. A wrong accumulator value or flag therefore shows up in the first read after the faulty write edge, one cycle later at most. A fault in a scan counter can hide until the accumulator holds a pattern that reaches the faulty bit. For that reason the scans are read across all-zero, all-ones, and short or long runs at both ends of the word. Carry-in paths are only seen when a preceding operation has left carry set, so add-with-carry and subtract-with-borrow are each run with carry set.

// File: rtl/acc_alu_pkg.sv
// Package: shared operation encoding for the write-triggered accumulator.
// The enumeration value of each operation equals its register offset; the
// address decoder relies on that identity.
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ACC = 4'd0,
        OP_AND = 4'd1,
        OP_OR  = 4'd2,
        OP_XOR = 4'd3,
        OP_ADD = 4'd4,
        OP_ADC = 4'd5,
        OP_SUB = 4'd6,
        OP_SBB = 4'd7,
        OP_CMP = 4'd8
    } op_e;

    // Number of mapped offsets; offsets at or above this are unmapped.
    localparam int unsigned OP_COUNT = 9;

endpackage

// File: rtl/acc_alu_decode.sv
// Module: acc_alu_decode
// Maps a register offset onto an operation and flags whether the offset is
// mapped at all. Assumes ADDR_W >= 4; bits above the low nibble must be zero
// for a hit.
module acc_alu_decode
    import acc_alu_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output op_e               op,
    output logic              hit
);

    logic upper_clear;

    generate
        if (ADDR_W > 4) begin : g_upper
            assign upper_clear = ~|addr[ADDR_W-1:4];
        end else begin : g_no_upper
            assign upper_clear = 1'b1;
        end
    endgenerate

    // Purpose: classify the offset and convert it to an operation code.
    always_comb begin
        hit = upper_clear && (addr[3:0] < 4'(OP_COUNT));
        op  = hit ? op_e'(addr[3:0]) : OP_ACC;
    end

endmodule

// File: rtl/acc_alu_exec.sv
// Module: acc_alu_exec
// Combinational datapath: given the current accumulator, carry and an operand,
// produces the next accumulator and flag values for one operation. Carry-in is
// only used by the add-with-carry and subtract-with-borrow operations. For the
// subtracting forms the carry output is the borrow out of the top bit.
module acc_alu_exec
    import acc_alu_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  op_e          op,
    input  logic [W-1:0] acc,
    input  logic         carry,
    input  logic [W-1:0] operand,
    output logic [W-1:0] acc_nxt,
    output logic         carry_nxt,
    output logic         zero_nxt
);

    logic         cin;
    logic [W:0]   sum_ext;
    logic [W:0]   diff_ext;

    // Purpose: shared W+1-bit adder and subtractor with optional carry-in.
    always_comb begin
        cin      = ((op == OP_ADC) || (op == OP_SBB)) ? carry : 1'b0;
        sum_ext  = {1'b0, acc} + {1'b0, operand} + {{W{1'b0}}, cin};
        diff_ext = {1'b0, acc} - {1'b0, operand} - {{W{1'b0}}, cin};
    end

    // Purpose: select result and flag update for the requested operation.
    always_comb begin
        acc_nxt   = acc;
        carry_nxt = carry;
        case (op)
            OP_ACC: acc_nxt = operand;
            OP_AND: begin
                acc_nxt   = acc & operand;
                carry_nxt = 1'b0;
            end
            OP_OR: begin
                acc_nxt   = acc | operand;
                carry_nxt = 1'b0;
            end
            OP_XOR: begin
                acc_nxt   = acc ^ operand;
                carry_nxt = 1'b0;
            end
            OP_ADD, OP_ADC: begin
                acc_nxt   = sum_ext[W-1:0];
                carry_nxt = sum_ext[W];
            end
            OP_SUB, OP_SBB: begin
                acc_nxt   = diff_ext[W-1:0];
                carry_nxt = diff_ext[W];
            end
            OP_CMP: carry_nxt = diff_ext[W];
            default: ;
        endcase
        zero_nxt = (op == OP_CMP) ? ~|diff_ext[W-1:0] : ~|acc_nxt;
    end

endmodule

// File: rtl/acc_alu_run.sv
// Module: acc_alu_run
// Counts the zeros below the lowest set bit of a vector (W when the vector is
// all zero). Callers feed an inverted or bit-reversed copy to obtain the other
// three scan directions.
module acc_alu_run #(
    parameter int unsigned W  = 64,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);

    logic found;

    // Purpose: priority search from bit 0 for the first one.
    always_comb begin
        cnt   = CW'(W);
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (!found && vec[i]) begin
                cnt   = CW'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/acc_alu_scan.sv
// Module: acc_alu_scan
// Status counters over the accumulator: population count and the four run
// lengths (ones/zeros from the low end, ones/zeros from the high end). Purely
// combinational; assumes the caller zero-extends the CW-bit results.
module acc_alu_scan #(
    parameter int unsigned W  = 64,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  acc,
    output logic [CW-1:0] pop_cnt,
    output logic [CW-1:0] low_ones,
    output logic [CW-1:0] low_zeros,
    output logic [CW-1:0] high_ones,
    output logic [CW-1:0] high_zeros
);

    localparam int unsigned NSCAN = 4;

    logic [W-1:0]  acc_rev;
    logic [W-1:0]  scan_src [NSCAN];
    logic [CW-1:0] scan_cnt [NSCAN];

    // Bit reversal so the high-end scans reuse the low-end counter.
    generate
        for (genvar b = 0; b < W; b++) begin : g_rev
            assign acc_rev[b] = acc[W-1-b];
        end
    endgenerate

    // Purpose: pick the source word for each scan direction.
    always_comb begin
        scan_src[0] = ~acc;      // ones from the low end
        scan_src[1] = acc;       // zeros from the low end
        scan_src[2] = ~acc_rev;  // ones from the high end
        scan_src[3] = acc_rev;   // zeros from the high end
    end

    generate
        for (genvar s = 0; s < NSCAN; s++) begin : g_scan
            acc_alu_run #(.W(W), .CW(CW)) u_run (
                .vec (scan_src[s]),
                .cnt (scan_cnt[s])
            );
        end
    endgenerate

    // Purpose: population count by bitwise accumulation.
    always_comb begin
        pop_cnt = '0;
        for (int i = 0; i < W; i++) begin
            pop_cnt = pop_cnt + CW'(acc[i]);
        end
    end

    assign low_ones   = scan_cnt[0];
    assign low_zeros  = scan_cnt[1];
    assign high_ones  = scan_cnt[2];
    assign high_zeros = scan_cnt[3];

endmodule

// File: rtl/acc_alu_unit.sv
// Module: acc_alu_unit (top)
// Memory-mapped accumulator whose operations are triggered by writes to
// their offsets; reads of the same offsets return flag and bit-scan status.
// Assumes at most one access offset per cycle; a read together with a write
// observes the pre-write state. Reset is synchronous, active low.
module acc_alu_unit
    import acc_alu_pkg::*;
#(
    parameter int unsigned W      = 64,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      rd_data,
    output logic              carry_o,
    output logic              zero_o
);

    localparam int unsigned CW  = $clog2(W + 1);
    localparam int unsigned PAD = W - CW;

    op_e           op;
    logic          hit;
    logic [W-1:0]  acc_q;
    logic          carry_q;
    logic          zero_q;
    logic [W-1:0]  acc_nxt;
    logic          carry_nxt;
    logic          zero_nxt;
    logic [CW-1:0] pop_cnt;
    logic [CW-1:0] low_ones;
    logic [CW-1:0] low_zeros;
    logic [CW-1:0] high_ones;
    logic [CW-1:0] high_zeros;

    acc_alu_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (addr),
        .op   (op),
        .hit  (hit)
    );

    acc_alu_exec #(.W(W)) u_exec (
        .op        (op),
        .acc       (acc_q),
        .carry     (carry_q),
        .operand   (wr_data),
        .acc_nxt   (acc_nxt),
        .carry_nxt (carry_nxt),
        .zero_nxt  (zero_nxt)
    );

    acc_alu_scan #(.W(W), .CW(CW)) u_scan (
        .acc        (acc_q),
        .pop_cnt    (pop_cnt),
        .low_ones   (low_ones),
        .low_zeros  (low_zeros),
        .high_ones  (high_ones),
        .high_zeros (high_zeros)
    );

    // Purpose: commit accumulator and flags on a mapped write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
            zero_q  <= 1'b1;
        end else if (wr_en && hit) begin
            acc_q   <= acc_nxt;
            carry_q <= carry_nxt;
            zero_q  <= zero_nxt;
        end
    end

    // Purpose: read multiplexer returning state or status per offset.
    always_comb begin
        rd_data = '0;
        if (rd_en && hit) begin
            case (op)
                OP_ACC: rd_data = acc_q;
                OP_AND: rd_data = {{(W-1){1'b0}}, carry_q};
                OP_OR:  rd_data = {{(W-1){1'b0}}, zero_q};
                OP_XOR: rd_data = {{PAD{1'b0}}, pop_cnt};
                OP_ADD: rd_data = {{PAD{1'b0}}, low_ones};
                OP_ADC: rd_data = {{PAD{1'b0}}, low_zeros};
                OP_SUB: rd_data = {{PAD{1'b0}}, high_ones};
                OP_SBB: rd_data = {{PAD{1'b0}}, high_zeros};
                OP_CMP: rd_data = '1;
                default: rd_data = '0;
            endcase
        end
    end

    assign carry_o = carry_q;
    assign zero_o  = zero_q;

endmodule

// File: rtl/acc_alu_unit_chk.sv
// Module: acc_alu_unit_chk
// Property checker attached to acc_alu_unit by bind. Observes ports and the
// accumulator register; drives nothing.
module acc_alu_unit_chk #(
    parameter int unsigned W      = 64,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [W-1:0]      rd_data,
    input logic              carry_o,
    input logic              zero_o,
    input logic [W-1:0]      acc_q
);

    localparam int unsigned CW = $clog2(W + 1);

    logic rst_seen = 1'b0;

    // Purpose: remember that the previous cycle was in reset.
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen |-> (acc_q == '0 && !carry_o && zero_o)); // R1

    AST_LOGIC_CLEARS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == ADDR_W'(1) || addr == ADDR_W'(2) || addr == ADDR_W'(3)))
        |=> !carry_o); // R3

    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(8)) |=> $stable(acc_q)); // R6

    AST_CMP_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(8)) |-> (&rd_data)); // R6

    AST_ZERO_TRACKS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr < ADDR_W'(8)) |=> (zero_o == (acc_q == '0))); // R2

    AST_FLAG_READ_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == ADDR_W'(1) || addr == ADDR_W'(2)))
        |-> (rd_data[W-1:1] == '0)); // R7

    AST_POPCOUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(3)) |-> (rd_data == W'($countones(acc_q)))); // R8

    AST_SCAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr >= ADDR_W'(4) && addr <= ADDR_W'(7))
        |-> (rd_data <= W'(W))); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || addr >= ADDR_W'(9))
        |=> ($stable(acc_q) && $stable(carry_o) && $stable(zero_o))); // R11

    AST_NO_READ_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || addr >= ADDR_W'(9)) |-> (rd_data == '0)); // R11

    // CW is used only to keep the count width visible to readers.
    logic [CW-1:0] unused_cw;
    assign unused_cw = '0;

endmodule

bind acc_alu_unit acc_alu_unit_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .rd_data (rd_data),
    .carry_o (carry_o),
    .zero_o  (zero_o),
    .acc_q   (acc_q)
);

// File: tb/tb_acc_alu_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected read values computed from a
// reference model of the requirements; a monitor pops and compares them at
// the falling edge of the cycle in which the read is presented.
module tb_acc_alu_unit;

    localparam int W = 64;
    localparam int A = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [A-1:0] addr = '0;
    logic         rd_en = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         carry_o;
    logic         zero_o;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;

    logic [W-1:0] m_acc;
    logic         m_c;
    logic         m_z;

    always #4 clk = ~clk;

    acc_alu_unit #(.W(W), .ADDR_W(A)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .carry_o (carry_o),
        .zero_o  (zero_o)
    );

    function automatic int pop_of(logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic int run_lo(logic [W-1:0] v, logic b);
        int n = 0;
        while (n < W && v[n] == b) n++;
        return n;
    endfunction

    function automatic int run_hi(logic [W-1:0] v, logic b);
        int n = 0;
        while (n < W && v[W-1-n] == b) n++;
        return n;
    endfunction

    function automatic logic [W-1:0] model_read(int a);
        case (a)
            0: return m_acc;
            1: return W'(m_c);
            2: return W'(m_z);
            3: return W'(pop_of(m_acc));
            4: return W'(run_lo(m_acc, 1'b1));
            5: return W'(run_lo(m_acc, 1'b0));
            6: return W'(run_hi(m_acc, 1'b1));
            7: return W'(run_hi(m_acc, 1'b0));
            8: return '1;
            default: return '0;
        endcase
    endfunction

    task automatic model_write(int a, logic [W-1:0] d);
        logic [W:0] t;
        case (a)
            0: m_acc = d;
            1: begin m_acc = m_acc & d; m_c = 1'b0; end
            2: begin m_acc = m_acc | d; m_c = 1'b0; end
            3: begin m_acc = m_acc ^ d; m_c = 1'b0; end
            4, 5: begin
                t = {1'b0, m_acc} + {1'b0, d} + ((a == 5) ? (W+1)'(m_c) : '0);
                m_acc = t[W-1:0]; m_c = t[W];
            end
            6, 7, 8: begin
                t = {1'b0, m_acc} - {1'b0, d} - ((a == 7) ? (W+1)'(m_c) : '0);
                m_c = (m_acc < d) || ((a == 7) && m_c && (m_acc == d));
                if (a != 8) m_acc = t[W-1:0];
                else begin
                    m_z = (t[W-1:0] == '0);
                    return;
                end
            end
            default: return;
        endcase
        m_z = (m_acc == '0);
    endtask

    // Present one access in the next cycle; reads are queued for the monitor.
    task automatic access(bit w, bit r, int a, logic [W-1:0] d, string tag);
        @(posedge clk);
        #1;
        addr    = A'(a);
        wr_en   = w;
        rd_en   = r;
        wr_data = d;
        if (r) sb_q.push_back('{exp: model_read(a), tag: tag});
        if (w) model_write(a, d);
    endtask

    task automatic wr(int a, logic [W-1:0] d, string tag);
        access(1'b1, 1'b0, a, d, tag);
    endtask

    task automatic rd(int a, string tag);
        access(1'b0, 1'b1, a, '0, tag);
    endtask

    task automatic check_flags(string tag);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        rd_en = 1'b0;
        checks++;
        if (carry_o !== m_c || zero_o !== m_z) begin
            failures++;
            $display("FAIL %s flags actual c=%b z=%b expected c=%b z=%b",
                     tag, carry_o, zero_o, m_c, m_z);
        end
    endtask

    task automatic all_scans(string tag);
        for (int k = 3; k <= 7; k++) rd(k, tag);
    endtask

    // Monitor: compare each presented read against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            checks++;
            if (sb_q.size() == 0) begin
                failures++;
                $display("FAIL %s unexpected read actual=%h expected=none", "scoreboard", rd_data);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                if (rd_data !== it.exp) begin
                    failures++;
                    $display("FAIL %s addr=%0d actual=%h expected=%h",
                             it.tag, addr, rd_data, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        m_acc = '0; m_c = 1'b0; m_z = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd(0, "R1 acc");
        rd(1, "R1 carry");
        rd(2, "R1 zero");
        check_flags("R1");

        // R2: direct load and read back
        wr(0, 64'h0123_4567_89AB_CDEF, "R2");
        rd(0, "R2 acc");
        check_flags("R2");

        // R3: logic operations clear carry
        wr(0, '1, "R3");
        wr(4, 64'd1, "R3 set carry");
        check_flags("R3 carry set");
        wr(0, 64'hF0F0_1234_5678_0F0F, "R3");
        wr(1, 64'hFF00_FF00_FF00_FF00, "R3 and");
        rd(0, "R3 and");
        wr(2, 64'h0000_0000_0000_00AA, "R3 or");
        rd(0, "R3 or");
        wr(3, m_acc, "R3 xor self");
        rd(0, "R3 xor");
        rd(2, "R3 zero after xor");
        check_flags("R3");

        // R4: add and add-with-carry
        wr(0, '1, "R4");
        wr(4, 64'd1, "R4 wrap");
        rd(1, "R4 carry out");
        rd(2, "R4 zero");
        wr(5, 64'd5, "R4 adc");
        rd(0, "R4 adc sum");
        check_flags("R4");

        // R5: subtract and subtract-with-borrow
        wr(6, 64'd7, "R5 sub borrow");
        rd(0, "R5 sub");
        rd(1, "R5 borrow");
        wr(7, 64'd0, "R5 sbb");
        rd(0, "R5 sbb");
        wr(7, 64'h10, "R5 sbb no borrow in");
        rd(0, "R5 sbb2");
        check_flags("R5");

        // R6: compare leaves the accumulator alone
        wr(0, 64'd100, "R6");
        wr(8, 64'd100, "R6 equal");
        rd(0, "R6 acc kept");
        rd(2, "R6 zero eq");
        wr(8, 64'd101, "R6 less");
        rd(1, "R6 borrow");
        rd(8, "R6 all ones");
        check_flags("R6");

        // R7 R8 R9 R10: flag and scan reads over several patterns
        rd(1, "R7 carry read");
        rd(2, "R7 zero read");
        wr(0, 64'h0000_0000_0000_00F7, "R9");
        all_scans("R8 R9 R10 low pattern");
        wr(0, 64'hF000_0000_0000_0000, "R10");
        all_scans("R8 R9 R10 high pattern");
        wr(0, '0, "R9");
        all_scans("R8 R9 R10 all zero");
        wr(0, '1, "R10");
        all_scans("R8 R9 R10 all ones");
        wr(0, 64'h7FFF_FFFF_FFFF_FFFE, "R10");
        all_scans("R8 R9 R10 inner run");

        // R11: unmapped offsets and idle strobes
        rd(9, "R11 unmapped read");
        rd(15, "R11 unmapped read top");
        wr(12, 64'hDEAD, "R11 unmapped write");
        rd(0, "R11 acc after unmapped");
        access(1'b0, 1'b0, 0, 64'h1234, "R11 idle");
        rd(0, "R11 acc after idle");
        check_flags("R11");

        // R12: read and write together
        access(1'b1, 1'b1, 0, 64'h55, "R12 same cycle old value");
        rd(0, "R12 new value");
        access(1'b1, 1'b1, 4, 64'h1, "R12 add read old scan");
        rd(0, "R12 add result");

        // R13: flag ports after a borrow
        wr(6, 64'h100, "R13");
        check_flags("R13 ports");

        @(posedge clk);
        #1;
        rd_en = 1'b0;
        wr_en = 1'b0;
        @(posedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard pending actual=%0d expected=0", sb_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule